// File: doc/BRIEF.md
# PCI Target Disconnect Controller

This block is the control core of a PCI bus target. It claims a transaction when the address decoder reports a hit during an address phase. It then paces the data phases with TRDY# according to the initiator's IRDY# and the back end's readiness. When the back end asks for it, or when an internal burst limit is reached, it ends the burst with a disconnect: STOP# is driven together with TRDY#. The back end sees one transfer strobe for every completed data phase.

After a disconnect the controller stays in a backoff state. It holds STOP# and DEVSEL# and keeps TRDY# deasserted until the FRAME# pin itself is sampled high, however long the initiator takes. No fixed release delay is assumed, so an initiator that keeps FRAME# low for extra clocks can neither cause a second transfer nor restart a data phase. After that, all three control lines are driven high for turnaround and are released once FRAME# and IRDY# are both idle.

The AD/CBE datapath, parity, configuration space and the master side are handled by other blocks.

Top module: `pci_tgt_ctrl`

## Requirements
- R1: Out of reset, DEVSEL#, TRDY# and STOP# are high, their output enables are low and the transfer strobe is low.
- R2: A hit sampled in idle together with FRAME# low makes DEVSEL# low with its enable high in the next cycle. TRDY# stays high during that claim cycle.
- R3: TRDY# is asserted only in the cycle after an edge at which IRDY# was sampled low during the current data phase. After every completed transfer TRDY# goes high for at least one cycle.
- R4: The transfer strobe is high exactly in the cycles whose closing edge samples IRDY# and TRDY# both low. A transaction produces exactly as many strobes as data phases completed.
- R5: While the back-end ready input is sampled low, TRDY# is not asserted.
- R6: A disconnect request sampled high when TRDY# is about to be asserted, in a phase that is not the initiator's final one (FRAME# low), asserts STOP# together with that TRDY#. That transfer completes and no further transfer follows in the transaction.
- R7: With the limit enabled, the phase holding transfer number BURST_MAX (default 8) carries STOP# with its TRDY#, unless FRAME# is already high in that phase.
- R8: After a disconnecting transfer, STOP# stays low, TRDY# high and the strobe low for as long as FRAME# is sampled low, for any number of cycles.
- R9: The backoff exit takes FRAME# straight from the pin. STOP# goes high in the cycle right after the first edge that samples FRAME# high in backoff.
- R10: On leaving a transaction, DEVSEL#, TRDY# and STOP# are driven high with enables on for at least one cycle. The enables drop in the cycle after an edge that samples both FRAME# and IRDY# high.
- R11: A transfer in a phase with FRAME# high ends the transaction without STOP#, going straight to turnaround.
- R12: A hit with FRAME# high in idle is ignored: DEVSEL# and its enable are unchanged in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PCI clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_n | input | 1 | FRAME# from the bus pin |
| irdy_n | input | 1 | IRDY# from the bus pin |
| addr_hit | input | 1 | Address decoder hit, valid in the address phase |
| be_ready | input | 1 | Back end can take or give a word |
| be_disc_req | input | 1 | Back end asks to end the burst after the next transfer |
| devsel_n | output | 1 | DEVSEL# value |
| devsel_oe | output | 1 | DEVSEL# output enable |
| trdy_n | output | 1 | TRDY# value |
| trdy_oe | output | 1 | TRDY# output enable |
| stop_n | output | 1 | STOP# value |
| stop_oe | output | 1 | STOP# output enable |
| xfer | output | 1 | Transfer strobe: data moves at the closing edge |

## Verification
DEVSEL# follows a hit by one cycle. The first TRDY# comes two cycles after the claim cycle's edge, and every later TRDY# comes one cycle after IRDY# is driven low with the back end ready. The strobe is high in the same cycle as TRDY# because it is formed from TRDY# and the IRDY# pin. STOP# is released one cycle after FRAME# is sampled high, and the enables drop one cycle after FRAME# and IRDY# are both sampled high. The initiator model drives on falling edges and checks every one of these cycles a moment later. A monitor counts strobes and STOP# cycles per transaction and compares them with the expected transfer count and disconnect flag that the driver queued, computed from the transaction length, the disconnect index and the burst limit.

// File: rtl/tgt_pkg.sv
package tgt_pkg;

   typedef enum logic [2:0] {
      T_IDLE    = 3'd0,
      T_CLAIM   = 3'd1,
      T_DATA    = 3'd2,
      T_BACKOFF = 3'd3,
      T_TURN    = 3'd4
   } tgt_state_e;

endpackage

// File: rtl/tgt_burst_cnt.sv
module tgt_burst_cnt #(
   parameter int BURST_MAX = 8,
   parameter bit LIMIT_EN  = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic inc,
   output logic last
);

   localparam int CW = $clog2(BURST_MAX + 1);

   if (BURST_MAX < 2) begin : g_bad_max
      $error("tgt_burst_cnt: BURST_MAX must be at least 2");
   end

   generate
      if (LIMIT_EN) begin : g_limit
         logic [CW-1:0] cnt_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q <= '0;
            end else if (clr) begin
               cnt_q <= '0;
            end else if (inc && (cnt_q != CW'(BURST_MAX))) begin
               cnt_q <= cnt_q + 1'b1;
            end
         end

         assign last = (cnt_q == CW'(BURST_MAX - 1));

         // R7
         cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
            cnt_q <= CW'(BURST_MAX));
      end else begin : g_nolimit
         logic unused_in;
         assign unused_in = clr ^ inc;
         assign last      = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/tgt_fsm.sv
module tgt_fsm
   import tgt_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       frame_n,
   input  logic       irdy_n,
   input  logic       addr_hit,
   input  logic       be_ready,
   input  logic       be_disc_req,
   input  logic       burst_last,
   output tgt_state_e state_q,
   output logic       trdy_q,
   output logic       stop_q,
   output logic       xfer
);

   tgt_state_e state_d;
   logic       trdy_d;
   logic       stop_d;

   assign xfer = (state_q == T_DATA) && trdy_q && !irdy_n;

   always_comb begin
      state_d = state_q;
      trdy_d  = trdy_q;
      stop_d  = stop_q;
      unique case (state_q)
         T_IDLE: begin
            trdy_d = 1'b0;
            stop_d = 1'b0;
            if (addr_hit && !frame_n) state_d = T_CLAIM;
         end
         T_CLAIM: begin
            state_d = T_DATA;
         end
         T_DATA: begin
            if (trdy_q) begin
               if (!irdy_n) begin
                  trdy_d = 1'b0;
                  stop_d = 1'b0;
                  if (stop_q)       state_d = T_BACKOFF;
                  else if (frame_n) state_d = T_TURN;
               end
            end else if (frame_n && irdy_n) begin
               state_d = T_TURN;
            end else if (!irdy_n && be_ready) begin
               trdy_d = 1'b1;
               stop_d = !frame_n && (be_disc_req || burst_last);
            end
         end
         T_BACKOFF: begin
            trdy_d = 1'b0;
            stop_d = 1'b0;
            // raw pin, no resampling stage
            if (frame_n) state_d = T_TURN;
         end
         T_TURN: begin
            trdy_d = 1'b0;
            stop_d = 1'b0;
            if (frame_n && irdy_n) state_d = T_IDLE;
         end
         default: begin
            state_d = T_IDLE;
            trdy_d  = 1'b0;
            stop_d  = 1'b0;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= T_IDLE;
         trdy_q  <= 1'b0;
         stop_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         trdy_q  <= trdy_d;
         stop_q  <= stop_d;
      end
   end

   // R3
   trdy_after_irdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(trdy_q) |-> $past(!irdy_n));

   // R8
   backoff_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == T_BACKOFF && !frame_n) |=> (state_q == T_BACKOFF && !trdy_q));

   // R6
   disc_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer && stop_q) |=> (state_q == T_BACKOFF && !trdy_q));

endmodule

// File: rtl/tgt_pad_drv.sv
module tgt_pad_drv
   import tgt_pkg::*;
(
   input  tgt_state_e state_q,
   input  logic       trdy_q,
   input  logic       stop_q,
   output logic       devsel_n,
   output logic       devsel_oe,
   output logic       trdy_n,
   output logic       trdy_oe,
   output logic       stop_n,
   output logic       stop_oe
);

   logic active;
   logic in_data;

   assign active  = (state_q != T_IDLE);
   assign in_data = (state_q == T_DATA);

   assign devsel_n  = !((state_q == T_CLAIM) || in_data || (state_q == T_BACKOFF));
   assign trdy_n    = !(in_data && trdy_q);
   assign stop_n    = !((in_data && stop_q) || (state_q == T_BACKOFF));
   assign devsel_oe = active;
   assign trdy_oe   = active;
   assign stop_oe   = active;

endmodule

// File: rtl/pci_tgt_ctrl.sv
module pci_tgt_ctrl
   import tgt_pkg::*;
#(
   parameter int BURST_MAX = 8,
   parameter bit LIMIT_EN  = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic frame_n,
   input  logic irdy_n,
   input  logic addr_hit,
   input  logic be_ready,
   input  logic be_disc_req,
   output logic devsel_n,
   output logic devsel_oe,
   output logic trdy_n,
   output logic trdy_oe,
   output logic stop_n,
   output logic stop_oe,
   output logic xfer
);

   tgt_state_e state_q;
   logic       trdy_q;
   logic       stop_q;
   logic       burst_last;

   tgt_fsm u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .frame_n     (frame_n),
      .irdy_n      (irdy_n),
      .addr_hit    (addr_hit),
      .be_ready    (be_ready),
      .be_disc_req (be_disc_req),
      .burst_last  (burst_last),
      .state_q     (state_q),
      .trdy_q      (trdy_q),
      .stop_q      (stop_q),
      .xfer        (xfer)
   );

   tgt_burst_cnt #(
      .BURST_MAX (BURST_MAX),
      .LIMIT_EN  (LIMIT_EN)
   ) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (state_q == T_IDLE),
      .inc   (xfer),
      .last  (burst_last)
   );

   tgt_pad_drv u_pad (
      .state_q   (state_q),
      .trdy_q    (trdy_q),
      .stop_q    (stop_q),
      .devsel_n  (devsel_n),
      .devsel_oe (devsel_oe),
      .trdy_n    (trdy_n),
      .trdy_oe   (trdy_oe),
      .stop_n    (stop_n),
      .stop_oe   (stop_oe)
   );

   // R4
   xfer_claimed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      xfer |-> (!devsel_n && !trdy_n && !irdy_n));

   // R10
   oe_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(stop_oe) |-> ($past(stop_n) && $past(frame_n) && $past(irdy_n)));

   // R12
   hit_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!devsel_oe && frame_n) |=> !devsel_oe);

endmodule

// File: tb/pci_tgt_ctrl_bench.sv
module pci_tgt_ctrl_bench;

   localparam int LIMIT = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic frame_n = 1'b1;
   logic irdy_n = 1'b1;
   logic addr_hit = 1'b0;
   logic be_ready = 1'b1;
   logic be_disc_req = 1'b0;
   logic devsel_n, devsel_oe, trdy_n, trdy_oe, stop_n, stop_oe, xfer;

   int n_chk = 0;
   int n_bad = 0;
   int exp_cnt_q[$];
   bit exp_stop_q[$];
   int mon_cnt = 0;
   bit mon_stop = 1'b0;
   bit mon_prev_oe = 1'b0;

   always #10 clk = ~clk;

   pci_tgt_ctrl #(.BURST_MAX(LIMIT)) u_pci_tgt_ctrl (
      .clk, .rst_n, .frame_n, .irdy_n, .addr_hit, .be_ready, .be_disc_req,
      .devsel_n, .devsel_oe, .trdy_n, .trdy_oe, .stop_n, .stop_oe, .xfer
   );

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
      end
   endtask

   task automatic finish_run();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   // scoreboard monitor: counts strobes and STOP# per transaction
   always begin
      @(negedge clk);
      #5;
      if (rst_n) begin
         if (xfer) mon_cnt++;
         if (!stop_n) mon_stop = 1'b1;
         if (mon_prev_oe && !devsel_oe) begin
            if (exp_cnt_q.size() == 0) begin
               check(1'b0, "R4", "unexpected transaction", mon_cnt, -1);
            end else begin
               int  ec;
               bit  es;
               ec = exp_cnt_q.pop_front();
               es = exp_stop_q.pop_front();
               // R4 strobe count, R6/R7 disconnect seen
               check(mon_cnt == ec, "R4", "strobes per transaction", mon_cnt, ec);
               check(mon_stop == es, "R6", "stop seen in transaction", int'(mon_stop), int'(es));
            end
            mon_cnt  = 0;
            mon_stop = 1'b0;
         end
         mon_prev_oe = devsel_oe;
      end
   end

   // driver: initiator model
   task automatic run_txn(input int len, input int disc_at, input int extra,
                          input bit iwait, input int rdy_gap);
      int  n;
      int  stop_ph;
      int  exp_n;
      bit  exp_stop;
      stop_ph  = (disc_at + 1 < LIMIT) ? disc_at + 1 : LIMIT;
      exp_stop = (stop_ph < len);
      exp_n    = exp_stop ? stop_ph : len;
      exp_cnt_q.push_back(exp_n);
      exp_stop_q.push_back(exp_stop);

      @(negedge clk);
      frame_n = 1'b0; irdy_n = 1'b1; addr_hit = 1'b1;
      @(negedge clk);
      addr_hit = 1'b0;
      #1;
      // R2
      check(!devsel_n && devsel_oe, "R2", "devsel after hit", int'(devsel_n), 0);
      check(trdy_n, "R2", "trdy high in claim", int'(trdy_n), 1);
      @(negedge clk);
      n = 0;
      forever begin
         be_disc_req = (n == disc_at);
         #1;
         // R3 TRDY# drops after every transfer
         check(trdy_n && !xfer, "R3", "trdy high at phase start", int'(trdy_n), 1);
         if (iwait) begin
            irdy_n = 1'b1; be_ready = 1'b1;
            @(negedge clk);
            #1;
            // R3 no TRDY# while IRDY# high
            check(trdy_n, "R3", "trdy during initiator wait", int'(trdy_n), 1);
         end
         irdy_n   = 1'b0;
         frame_n  = (n + 1 == len);
         be_ready = (rdy_gap == 0);
         for (int g = 0; g < rdy_gap; g++) begin
            @(negedge clk);
            #1;
            // R5
            check(trdy_n, "R5", "trdy held off by back end", int'(trdy_n), 1);
            if (g == rdy_gap - 1) be_ready = 1'b1;
         end
         @(negedge clk);
         #1;
         check(!trdy_n && xfer, "R4", "trdy with strobe", int'(trdy_n), 0);
         n++;
         if (exp_stop && n == exp_n) begin
            check(!stop_n, (stop_ph == LIMIT) ? "R7" : "R6", "stop with last trdy", int'(stop_n), 0);
         end else begin
            check(stop_n, "R11", "no stop in ordinary phase", int'(stop_n), 1);
         end
         @(negedge clk);
         if (!stop_n || n == len || n >= exp_n) break;
      end
      be_disc_req = 1'b0;
      if (exp_stop) begin
         for (int i = 0; i <= extra; i++) begin
            frame_n = (i == extra);
            #1;
            // R8
            check(!stop_n && trdy_n && !xfer, "R8", "stop held in backoff", int'(stop_n), 0);
            @(negedge clk);
         end
         #1;
         // R9 released one cycle after FRAME# high
         check(stop_n && stop_oe, "R9", "stop released after frame high", int'(stop_n), 1);
         check(devsel_n && trdy_n, "R10", "turnaround drives high", int'(devsel_n), 1);
      end else begin
         #1;
         // R11
         check(stop_n && trdy_n && devsel_oe, "R11", "final phase ends without stop", int'(stop_n), 1);
      end
      irdy_n = 1'b1; frame_n = 1'b1;
      @(negedge clk);
      #1;
      // R10
      check(!devsel_oe && !trdy_oe && !stop_oe, "R10", "enables released", int'(devsel_oe), 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      #1;
      // R1
      check(devsel_n && trdy_n && stop_n, "R1", "outputs high in reset", int'(stop_n), 1);
      check(!devsel_oe && !trdy_oe && !stop_oe && !xfer, "R1", "enables low in reset", int'(devsel_oe), 0);
      rst_n = 1'b1;
      @(negedge clk);
      #1;
      check(!devsel_oe && !xfer, "R1", "idle after reset", int'(devsel_oe), 0);

      // R12 hit without FRAME# low
      addr_hit = 1'b1; frame_n = 1'b1;
      @(negedge clk);
      addr_hit = 1'b0;
      #1;
      check(!devsel_oe && devsel_n, "R12", "hit with frame high ignored", int'(devsel_oe), 0);

      run_txn(2, 99, 0, 1'b0, 0);   // plain two-word burst
      run_txn(4, 1, 0, 1'b0, 0);    // disconnect after word 2, prompt release
      run_txn(5, 2, 1, 1'b1, 0);    // initiator waits, one extra FRAME# cycle
      run_txn(12, 99, 3, 1'b0, 0);  // burst limit, three extra FRAME# cycles
      run_txn(3, 99, 0, 1'b0, 2);   // back end stalls
      run_txn(8, 99, 0, 1'b0, 0);   // limit reached on initiator's last phase
      run_txn(6, 0, 3, 1'b0, 1);    // immediate disconnect, slow release
      run_txn(1, 99, 0, 1'b1, 0);   // single word

      repeat (4) @(negedge clk);
      check(exp_cnt_q.size() == 0, "R4", "all transactions compared", exp_cnt_q.size(), 0);
      finish_run();
   end

   initial begin
      repeat (20000) @(posedge clk);
      check(1'b0, "R1", "watchdog expired", 0, 1);
      finish_run();
   end

endmodule